// File: doc/BRIEF.md
# Exception entry sequencer

This block carries out the hardware steps a small processor core takes when it enters an exception or interrupt handler. The block samples three request classes while idle: a software break, a non-maskable interrupt and an external vectored interrupt. It picks one of them. It then captures the current program counter, status word, stack pointer, kernel stack pointer and vector base. From these it builds the new context over a short fixed sequence of states: select, save, stack swap and table fetch.

The handler address comes from a single-word read port. The read address is the vector base plus four times the chosen vector number. All context outputs change together on the cycle the entry completes, and a one-cycle done pulse marks that cycle. A bus-fault request, or a request made while the prefix bit of the status word is set, is refused with a one-cycle error pulse and is not entered.

Top module: `exc_entry_seq`

## Requirements
- R1: Request priority while idle.
  - A bus-fault request causes rejection.
  - Otherwise a non-maskable request wins over an external interrupt, and an external interrupt wins over a break.
  - An external interrupt is ignored while `irq_lock` is 1.
- R2: A break entry uses `trap_vec` as its vector number and writes `cur_pc` into `erp_out`. `nrp_out` is left unchanged.
- R3: A non-maskable entry uses vector 0 and writes `cur_pc` into `nrp_out`. `erp_out` is left unchanged. Status bit 1 (the interrupt enable flag) is cleared; all other status bits are kept.
- R4: An external interrupt entry uses `irq_vec` as its vector number and writes `cur_pc` into `erp_out`.
- R5: Stack handling depends on status bit 0 (user mode) at entry.
  - If the bit is 1, `usp_out` takes `cur_sp` and `sp_out` takes `kern_sp`.
  - Otherwise `sp_out` takes `cur_sp` and `usp_out` is unchanged.
- R6: The block drives `mem_rd_req` with `mem_rd_addr` = `vec_base` + 4 × vector, holding both steady until `mem_rd_valid` is 1. `pc_out` then takes `mem_rd_data`.
- R7: `entry_done` is high for exactly one cycle per entry. The context outputs change only in the cycle where `entry_done` is high.
- R8: Every completed entry sets `irq_lock`. A `lock_release` pulse clears it.
- R9: A bus-fault request gives a one-cycle `entry_err` pulse in the cycle after it is sampled. No memory read follows and the context outputs do not change.
- R10: A request made while status bit 2 (prefix pending) is set is refused in the same way as R9.
- R11: Requests that arrive while an entry is in progress are ignored.
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_req | input | 1 | Software break request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | External maskable interrupt request |
| bus_fault_req | input | 1 | Bus-fault request (always refused) |
| trap_vec | input | VEC_W | Vector number for breaks |
| irq_vec | input | VEC_W | Vector number from the interrupt controller |
| cur_pc | input | XLEN | Current program counter |
| cur_status | input | STAT_W | Current status word |
| cur_sp | input | XLEN | Current stack pointer |
| kern_sp | input | XLEN | Kernel stack pointer |
| vec_base | input | XLEN | Vector table base |
| lock_release | input | 1 | Software release of the interrupt lock |
| mem_rd_req | output | 1 | Vector table read request |
| mem_rd_addr | output | XLEN | Vector table read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | XLEN | Read data (handler address) |
| entry_done | output | 1 | One-cycle completion pulse |
| entry_err | output | 1 | One-cycle refusal pulse |
| irq_lock | output | 1 | Maskable interrupts blocked |
| pc_out | output | XLEN | New program counter |
| status_out | output | STAT_W | New status word |
| sp_out | output | XLEN | New stack pointer |
| usp_out | output | XLEN | Saved user stack pointer |
| erp_out | output | XLEN | Exception return address |
| nrp_out | output | XLEN | Non-maskable return address |

## Verification
The assertions check these properties on every cycle:
- the done pulse lasts one cycle;
- the read request holds until it is answered;
- context outputs move only with done;
- the lock is set whenever done is high;
- a non-maskable entry reads the table base and leaves the enable flag cleared;
- an error pulse never coincides with done.

Only the bench's directed scenarios can show the rest: the priority between simultaneous requests, the vector choice per class, the conditional stack swap, and that ignored or refused requests leave every output untouched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int ST_USER = 0;  // user-mode flag
  localparam int ST_MEN  = 1;  // interrupt enable flag cleared by NMI
  localparam int ST_PFX  = 2;  // prefix pending flag

  typedef enum logic [1:0] {
    CLS_BRK = 2'd0,
    CLS_NMI = 2'd1,
    CLS_IRQ = 2'd2
  } exc_cls_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SAVE  = 3'd1,
    S_SWAP  = 3'd2,
    S_FETCH = 3'd3,
    S_DONE  = 3'd4
  } entry_state_e;
endpackage

// File: rtl/exc_req_arbiter.sv
module exc_req_arbiter
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             brk_req,
  input  logic             nmi_req,
  input  logic             irq_req,
  input  logic             bus_fault_req,
  input  logic             irq_locked,
  input  logic             prefix_set,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             accept,
  output logic             reject,
  output exc_cls_e         cls,
  output logic [VEC_W-1:0] vec
);
  logic irq_ok;
  logic any_req;

  always_comb begin
    irq_ok  = irq_req && !irq_locked;
    any_req = nmi_req || irq_ok || brk_req;
    cls     = CLS_BRK;
    vec     = trap_vec;
    if (nmi_req) begin
      cls = CLS_NMI;
      vec = '0;
    end else if (irq_ok) begin
      cls = CLS_IRQ;
      vec = irq_vec;
    end
    reject = bus_fault_req || (any_req && prefix_set);
    accept = any_req && !reject;
  end
endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
  import exc_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd_valid,
  output logic idle_ev,
  output logic latch_ev,
  output logic save_ev,
  output logic swap_ev,
  output logic fetch_ev,
  output logic commit_ev,
  output logic done_ev
);
  entry_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (start) state_nx = S_SAVE;
      S_SAVE:  state_nx = S_SWAP;
      S_SWAP:  state_nx = S_FETCH;
      S_FETCH: if (rd_valid) state_nx = S_DONE;
      S_DONE:  state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  assign idle_ev   = (state == S_IDLE);
  assign latch_ev  = idle_ev && start;
  assign save_ev   = (state == S_SAVE);
  assign swap_ev   = (state == S_SWAP);
  assign fetch_ev  = (state == S_FETCH);
  assign commit_ev = fetch_ev && rd_valid;
  assign done_ev   = (state == S_DONE);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !done_ev);
  a_r6_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ev && !rd_valid |=> fetch_ev);
  a_r7_done_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |-> $past(commit_ev));
endmodule

// File: rtl/exc_ctx_stage.sv
module exc_ctx_stage
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_en,
  input  logic              swap_en,
  input  exc_cls_e          cls,
  input  logic [XLEN-1:0]   pc,
  input  logic [STAT_W-1:0] status,
  input  logic [XLEN-1:0]   sp,
  input  logic [XLEN-1:0]   ksp,
  output logic [XLEN-1:0]   ret_addr,
  output logic              erp_wr,
  output logic              nrp_wr,
  output logic [STAT_W-1:0] status_new,
  output logic [XLEN-1:0]   sp_new,
  output logic [XLEN-1:0]   usp_new,
  output logic              usp_wr
);
  function automatic logic [STAT_W-1:0] drop_enable(input logic [STAT_W-1:0] st);
    logic [STAT_W-1:0] r;
    r         = st;
    r[ST_MEN] = 1'b0;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_addr   <= '0;
      erp_wr     <= 1'b0;
      nrp_wr     <= 1'b0;
      status_new <= '0;
      sp_new     <= '0;
      usp_new    <= '0;
      usp_wr     <= 1'b0;
    end else begin
      if (save_en) begin
        ret_addr   <= pc;
        erp_wr     <= (cls != CLS_NMI);
        nrp_wr     <= (cls == CLS_NMI);
        status_new <= (cls == CLS_NMI) ? drop_enable(status) : status;
      end
      if (swap_en) begin
        usp_wr  <= status[ST_USER];
        usp_new <= sp;
        sp_new  <= status[ST_USER] ? ksp : sp;
      end
    end
  end

  a_r3_ret_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    swap_en |-> !(erp_wr && nrp_wr));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int VEC_W  = 8,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic              bus_fault_req,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [STAT_W-1:0] cur_status,
  input  logic [XLEN-1:0]   cur_sp,
  input  logic [XLEN-1:0]   kern_sp,
  input  logic [XLEN-1:0]   vec_base,
  input  logic              lock_release,
  output logic              mem_rd_req,
  output logic [XLEN-1:0]   mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [XLEN-1:0]   mem_rd_data,
  output logic              entry_done,
  output logic              entry_err,
  output logic              irq_lock,
  output logic [XLEN-1:0]   pc_out,
  output logic [STAT_W-1:0] status_out,
  output logic [XLEN-1:0]   sp_out,
  output logic [XLEN-1:0]   usp_out,
  output logic [XLEN-1:0]   erp_out,
  output logic [XLEN-1:0]   nrp_out
);
  localparam int SLOT_SHIFT = 2;

  function automatic logic [XLEN-1:0] slot_addr(input logic [XLEN-1:0] base,
                                                 input logic [VEC_W-1:0] v);
    logic [XLEN-1:0] off;
    off = '0;
    off[VEC_W+SLOT_SHIFT-1:0] = {v, {SLOT_SHIFT{1'b0}}};
    return base + off;
  endfunction

  logic             arb_accept, arb_reject;
  exc_cls_e         arb_cls;
  logic [VEC_W-1:0] arb_vec;
  logic idle_ev, latch_ev, save_ev, swap_ev, fetch_ev, commit_ev, done_ev;

  exc_cls_e          cls_q;
  logic [VEC_W-1:0]  vec_q;
  logic [XLEN-1:0]   pc_q, sp_q, ksp_q, base_q;
  logic [STAT_W-1:0] st_q;
  logic              err_q;

  logic [XLEN-1:0]   ret_addr, sp_new, usp_new;
  logic [STAT_W-1:0] status_new;
  logic              erp_wr, nrp_wr, usp_wr;

  exc_req_arbiter #(.VEC_W(VEC_W)) u_arb (
    .brk_req(brk_req), .nmi_req(nmi_req), .irq_req(irq_req),
    .bus_fault_req(bus_fault_req), .irq_locked(irq_lock),
    .prefix_set(cur_status[ST_PFX]), .trap_vec(trap_vec), .irq_vec(irq_vec),
    .accept(arb_accept), .reject(arb_reject), .cls(arb_cls), .vec(arb_vec)
  );

  exc_entry_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(arb_accept), .rd_valid(mem_rd_valid),
    .idle_ev(idle_ev), .latch_ev(latch_ev), .save_ev(save_ev),
    .swap_ev(swap_ev), .fetch_ev(fetch_ev), .commit_ev(commit_ev),
    .done_ev(done_ev)
  );

  exc_ctx_stage #(.XLEN(XLEN), .STAT_W(STAT_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .save_en(save_ev), .swap_en(swap_ev),
    .cls(cls_q), .pc(pc_q), .status(st_q), .sp(sp_q), .ksp(ksp_q),
    .ret_addr(ret_addr), .erp_wr(erp_wr), .nrp_wr(nrp_wr),
    .status_new(status_new), .sp_new(sp_new), .usp_new(usp_new),
    .usp_wr(usp_wr)
  );

  // request capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_q  <= CLS_BRK;
      vec_q  <= '0;
      pc_q   <= '0;
      st_q   <= '0;
      sp_q   <= '0;
      ksp_q  <= '0;
      base_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= idle_ev && arb_reject;
      if (latch_ev) begin
        cls_q  <= arb_cls;
        vec_q  <= arb_vec;
        pc_q   <= cur_pc;
        st_q   <= cur_status;
        sp_q   <= cur_sp;
        ksp_q  <= kern_sp;
        base_q <= vec_base;
      end
    end
  end

  // atomic commit of the architectural context
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_out     <= '0;
      status_out <= '0;
      sp_out     <= '0;
      usp_out    <= '0;
      erp_out    <= '0;
      nrp_out    <= '0;
      irq_lock   <= 1'b0;
    end else if (commit_ev) begin
      pc_out     <= mem_rd_data;
      status_out <= status_new;
      sp_out     <= sp_new;
      if (usp_wr) usp_out <= usp_new;
      if (erp_wr) erp_out <= ret_addr;
      if (nrp_wr) nrp_out <= ret_addr;
      irq_lock   <= 1'b1;
    end else if (lock_release) begin
      irq_lock <= 1'b0;
    end
  end

  assign mem_rd_req  = fetch_ev;
  assign mem_rd_addr = slot_addr(base_q, vec_q);
  assign entry_done  = done_ev;
  assign entry_err   = err_q;

  a_r7_pc_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_out) |-> entry_done);
  a_r7_erp_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(erp_out) |-> entry_done);
  a_r7_sp_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_out) |-> entry_done);
  a_r8_lock_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |-> irq_lock);
  a_r3_nmi_slot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && cls_q == CLS_NMI |-> mem_rd_addr == base_q);
  a_r3_nmi_enable_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done && cls_q == CLS_NMI |-> !status_out[ST_MEN]);
  a_r9_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    entry_err |-> !entry_done);
  a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> $stable(mem_rd_addr));
endmodule

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brk_req = 0, nmi_req = 0, irq_req = 0, bus_fault_req = 0, lock_release = 0;
  logic [7:0]  trap_vec = 0, irq_vec = 0;
  logic [31:0] cur_pc = 0, cur_sp = 0, kern_sp = 0, vec_base = 0;
  logic [15:0] cur_status = 0;
  logic        mem_rd_req, mem_rd_valid;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        entry_done, entry_err, irq_lock;
  logic [31:0] pc_out, sp_out, usp_out, erp_out, nrp_out;
  logic [15:0] status_out;

  int checks = 0, fails = 0;
  int lat = 0, wcnt = 0;
  int done_cnt = 0, rd_cnt = 0;
  logic [31:0] last_addr = 0;

  always #5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .nmi_req(nmi_req),
    .irq_req(irq_req), .bus_fault_req(bus_fault_req), .trap_vec(trap_vec),
    .irq_vec(irq_vec), .cur_pc(cur_pc), .cur_status(cur_status),
    .cur_sp(cur_sp), .kern_sp(kern_sp), .vec_base(vec_base),
    .lock_release(lock_release), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .entry_done(entry_done), .entry_err(entry_err),
    .irq_lock(irq_lock), .pc_out(pc_out), .status_out(status_out),
    .sp_out(sp_out), .usp_out(usp_out), .erp_out(erp_out), .nrp_out(nrp_out)
  );

  function automatic logic [31:0] table_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction
  function automatic logic [31:0] slot(input logic [31:0] b, input int v);
    return b + 32'(v * 4);
  endfunction

  // vector table memory model with programmable wait states
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
      wcnt         <= 0;
    end else if (mem_rd_req && !mem_rd_valid) begin
      if (wcnt >= lat) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= table_word(mem_rd_addr);
        wcnt         <= 0;
      end else wcnt <= wcnt + 1;
    end else mem_rd_valid <= 1'b0;
  end

  always @(posedge clk) begin
    if (entry_done) done_cnt <= done_cnt + 1;
    if (mem_rd_req) begin rd_cnt <= rd_cnt + 1; last_addr <= mem_rd_addr; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b, input logic n, input logic i, input logic f);
    @(negedge clk);
    brk_req = b; nmi_req = n; irq_req = i; bus_fault_req = f;
    @(negedge clk);
    brk_req = 0; nmi_req = 0; irq_req = 0; bus_fault_req = 0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int k = 0; k < 60; k++) begin
      if (entry_done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk({tag, " done seen"}, 32'(seen), 32'd1);
  endtask

  task automatic done_gone(input string tag);
    @(negedge clk);
    chk({tag, " done one cycle"}, 32'(entry_done), 32'd0);
  endtask

  task automatic set_ctx(input logic [31:0] pc, input logic [15:0] st,
                         input logic [31:0] sp, input logic [31:0] ksp,
                         input logic [31:0] base);
    cur_pc = pc; cur_status = st; cur_sp = sp; kern_sp = ksp; vec_base = base;
  endtask

  task automatic t_reset;
    chk("R12 pc_out", pc_out, 0);
    chk("R12 status_out", 32'(status_out), 0);
    chk("R12 sp_out", sp_out, 0);
    chk("R12 usp_out", usp_out, 0);
    chk("R12 erp_out", erp_out, 0);
    chk("R12 nrp_out", nrp_out, 0);
    chk("R12 flags", {28'd0, irq_lock, entry_done, entry_err, mem_rd_req}, 0);
  endtask

  task automatic t_break_user;
    set_ctx(32'h1000, 16'h0003, 32'h8000, 32'h9000, 32'h4000);
    trap_vec = 8'd5; lat = 0;
    pulse(1, 0, 0, 0);
    wait_done("R2");
    chk("R6 break addr", last_addr, slot(32'h4000, 5));
    chk("R6 break pc_out", pc_out, table_word(slot(32'h4000, 5)));
    chk("R2 erp_out", erp_out, 32'h1000);
    chk("R2 nrp_out kept", nrp_out, 0);
    chk("R5 sp_out kernel", sp_out, 32'h9000);
    chk("R5 usp_out saved", usp_out, 32'h8000);
    chk("R2 status kept", 32'(status_out), 32'h0003);
    chk("R8 lock set", 32'(irq_lock), 1);
    done_gone("R7");
  endtask

  task automatic t_irq_kernel;
    @(negedge clk); lock_release = 1;
    @(negedge clk); lock_release = 0;
    chk("R8 lock released", 32'(irq_lock), 0);
    set_ctx(32'h2000, 16'h0002, 32'h7000, 32'h9100, 32'h4000);
    irq_vec = 8'h21; lat = 3;
    pulse(0, 0, 1, 0);
    wait_done("R4");
    chk("R6 irq addr", last_addr, slot(32'h4000, 33));
    chk("R4 pc_out", pc_out, table_word(slot(32'h4000, 33)));
    chk("R4 erp_out", erp_out, 32'h2000);
    chk("R5 sp_out unchanged", sp_out, 32'h7000);
    chk("R5 usp_out kept", usp_out, 32'h8000);
    done_gone("R7");
  endtask

  task automatic t_irq_locked;
    int d0, r0;
    logic [31:0] pc0;
    d0 = done_cnt; r0 = rd_cnt; pc0 = pc_out;
    chk("R1 lock held", 32'(irq_lock), 1);
    set_ctx(32'h2400, 16'h0002, 32'h7000, 32'h9100, 32'h4000);
    pulse(0, 0, 1, 0);
    repeat (12) @(negedge clk);
    chk("R1 locked irq no entry", 32'(done_cnt - d0), 0);
    chk("R1 locked irq no read", 32'(rd_cnt - r0), 0);
    chk("R1 locked irq pc_out", pc_out, pc0);
    trap_vec = 8'd9; irq_vec = 8'h30; lat = 1;
    pulse(1, 0, 1, 0);
    wait_done("R1");
    chk("R1 break wins over locked irq", last_addr, slot(32'h4000, 9));
    chk("R1 break erp_out", erp_out, 32'h2400);
    done_gone("R7");
  endtask

  task automatic t_nmi_vs_irq;
    @(negedge clk); lock_release = 1;
    @(negedge clk); lock_release = 0;
    set_ctx(32'h3000, 16'h0003, 32'h6000, 32'h9200, 32'h5000);
    irq_vec = 8'h11; trap_vec = 8'd4; lat = 2;
    pulse(1, 1, 1, 0);
    wait_done("R3");
    chk("R1 nmi wins slot", last_addr, 32'h5000);
    chk("R3 pc_out", pc_out, table_word(32'h5000));
    chk("R3 nrp_out", nrp_out, 32'h3000);
    chk("R3 erp_out kept", erp_out, 32'h2400);
    chk("R3 enable cleared", 32'(status_out), 32'h0001);
    chk("R5 nmi sp swap", sp_out, 32'h9200);
    chk("R5 nmi usp", usp_out, 32'h6000);
    chk("R8 lock after nmi", 32'(irq_lock), 1);
    done_gone("R7");
  endtask

  task automatic t_reject(input string tag, input logic f, input logic [15:0] st);
    int d0, r0;
    logic [31:0] pc0, sp0;
    d0 = done_cnt; r0 = rd_cnt; pc0 = pc_out; sp0 = sp_out;
    set_ctx(32'h7700, st, 32'h1111, 32'h2222, 32'h6000);
    @(negedge clk);
    brk_req = 1; bus_fault_req = f;
    @(negedge clk);
    brk_req = 0; bus_fault_req = 0;
    chk({tag, " err pulse"}, 32'(entry_err), 1);
    @(negedge clk);
    chk({tag, " err one cycle"}, 32'(entry_err), 0);
    repeat (8) @(negedge clk);
    chk({tag, " no entry"}, 32'(done_cnt - d0), 0);
    chk({tag, " no read"}, 32'(rd_cnt - r0), 0);
    chk({tag, " pc_out kept"}, pc_out, pc0);
    chk({tag, " sp_out kept"}, sp_out, sp0);
  endtask

  task automatic t_busy;
    int d0;
    logic [31:0] nrp0;
    d0 = done_cnt; nrp0 = nrp_out;
    set_ctx(32'h8800, 16'h0002, 32'h3300, 32'h9300, 32'h4000);
    trap_vec = 8'd7; lat = 6;
    pulse(1, 0, 0, 0);
    repeat (4) @(negedge clk);
    chk("R11 in fetch", 32'(mem_rd_req), 1);
    cur_pc = 32'hDEAD;
    pulse(0, 1, 0, 0);
    wait_done("R11");
    chk("R11 first entry addr", last_addr, slot(32'h4000, 7));
    chk("R11 first entry erp", erp_out, 32'h8800);
    repeat (12) @(negedge clk);
    chk("R11 single entry", 32'(done_cnt - d0), 1);
    chk("R11 nrp untouched", nrp_out, nrp0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_break_user();
    t_irq_kernel();
    t_irq_locked();
    t_nmi_vs_irq();
    t_reject("R9", 1'b1, 16'h0002);
    t_reject("R10", 1'b0, 16'h0006);
    t_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule